// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block sits behind the SPI front end of a serial NOR flash command decoder and decides whether an instruction that would change stored data is allowed to run. The front end presents a decoded instruction code with a one-cycle strobe at the moment chip select returns high. Alongside it come the number of serial clock pulses seen in the frame and the upper address bits that select a sector. The gate also reads the active-low write-protect pin, the status-register protection fields, the deep power-down state and the busy state of the program/erase engines.

The gate owns the write-enable latch. A write-enable instruction sets it and a write-disable instruction clears it. Once an accepted program, erase or status write finishes, the latch drops. For each modifying instruction the gate emits a one-cycle accept or reject pulse. An accept pulse is what starts the downstream engine. For page program and sector erase, the block-protect level marks a top slice of the 64 sectors as read-only, and the gate compares the targeted sector against that slice.

Top module: `wp_gate`

## Requirements
- R1: After reset the write-enable latch reads 0 and neither the accept pulse nor the reject pulse is high.
- R2: Instruction code 1 (write enable) sets the latch and code 2 (write disable) clears it, whatever the bit count. Neither code produces an accept or reject pulse.
- R3: Modifying instructions are code 3 (page program), 4 (sector erase), 5 (bulk erase) and 6 (status write). One of these issued while the latch is clear is rejected. A rejected instruction leaves the latch unchanged.
- R4: A modifying instruction whose bit count is not an exact multiple of eight is rejected.
- R5: Let L be the 3-bit block-protect level. L=0 protects no sector and L=7 protects all 64. L from 1 to 6 protects the top 2^(L-1) sectors. A page program or sector erase whose sector index (address bits 21..16, input `sec_addr`) falls in the protected range is rejected.
- R6: Bulk erase is accepted only when the protect level is 0.
- R7: A status write is rejected when the status-register lock bit is 1 and the write-protect pin is low.
- R8: While deep power-down is high, codes 1 to 6 are ignored. No pulse is produced and the latch does not change.
- R9: A modifying instruction that arrives while busy is high is rejected.
- R10: Accepting an instruction does not clear the latch. The latch clears on the next completion pulse after an accept. A completion pulse with no accepted operation outstanding has no effect.
- R11: Accept and reject are never high together. Each lasts one cycle and appears on the clock edge that samples the chip-select strobe. A modifying instruction that meets every condition above is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_rise | input | 1 | One-cycle strobe marking the end of an instruction frame |
| ins_kind | input | 3 | Decoded instruction code (0 none, 1 write enable, 2 write disable, 3 page program, 4 sector erase, 5 bulk erase, 6 status write) |
| bit_count | input | CNT_W | Serial clock pulses counted in the frame |
| sec_addr | input | SEC_W | Sector index taken from address bits 21..16 |
| wp_n | input | 1 | Write-protect pin, active low |
| srwd | input | 1 | Status-register lock bit |
| bp | input | BP_W | Block-protect level |
| dpd | input | 1 | Deep power-down state |
| busy | input | 1 | Program/erase engine busy |
| op_done | input | 1 | One-cycle pulse when the busy operation completes |
| accept | output | 1 | Instruction accepted, one-cycle pulse |
| reject | output | 1 | Instruction rejected, one-cycle pulse |
| wel | output | 1 | Write-enable latch state |

## Verification
The bench targets the edges of the protected slice. These are sectors 62 and 63 at level 1, sectors 31 and 32 at level 6, and sector 0 at level 7. An off-by-one in the size decode would pass a write to a read-only sector or refuse a legal one. It also targets frames one bit short of a byte boundary, which a design that ignored the count would wrongly accept. Latch timing is exercised by accepting an instruction, checking that the latch stays set until completion, and then sending a spurious completion pulse. A design that cleared the latch on acceptance, or on any completion pulse, would show the wrong latch state. Deep power-down combined with write disable, and the status write with the pin low and the lock bit set, catch designs that let either path through.

// File: rtl/wp_pkg.sv
package wp_pkg;
   typedef enum logic [2:0] {
      INS_NONE = 3'd0,
      INS_WREN = 3'd1,
      INS_WRDI = 3'd2,
      INS_PP   = 3'd3,
      INS_SE   = 3'd4,
      INS_BE   = 3'd5,
      INS_WRSR = 3'd6
   } ins_e;
endpackage

// File: rtl/wp_sector_map.sv
module wp_sector_map #(
   parameter int SEC_W    = 6,
   parameter int BP_W     = 3,
   parameter bit USE_MASK = 1'b1
) (
   input  logic [SEC_W-1:0] sec,
   input  logic [BP_W-1:0]  bp,
   output logic             hit
);
   localparam int NSEC = 1 << SEC_W;

   // number of sectors covered at the top of the array for a protect level
   function automatic int zone_size(logic [BP_W-1:0] lvl);
      if (lvl == '0) return 0;
      if (lvl == '1) return NSEC;
      return 1 << (int'(lvl) - 1);
   endfunction

   if (SEC_W != (1 << BP_W) - 2) begin : g_bad_geom
      $error("wp_sector_map: SEC_W must equal 2**BP_W-2");
   end

   if (USE_MASK) begin : g_mask
      logic [NSEC-1:0] mask;
      for (genvar s = 0; s < NSEC; s++) begin : g_s
         assign mask[s] = (s >= NSEC - zone_size(bp));
      end
      assign hit = mask[sec];
   end else begin : g_cmp
      assign hit = (int'(sec) >= NSEC - zone_size(bp));
   end
endmodule

// File: rtl/wp_admit.sv
module wp_admit
   import wp_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int BP_W  = 3
) (
   input  logic [2:0]       ins_kind,
   input  logic [CNT_W-1:0] bit_count,
   input  logic             wel,
   input  logic             busy,
   input  logic [BP_W-1:0]  bp,
   input  logic             srwd,
   input  logic             wp_n,
   input  logic             sec_hit,
   output logic             is_mod,
   output logic             ok
);
   localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);

   if (CNT_W < 4) begin : g_bad_cnt
      $error("wp_admit: CNT_W too small");
   end

   logic frame_ok;
   logic kind_ok;

   assign frame_ok = (bit_count % BYTE_BITS) == '0;

   always_comb begin
      is_mod  = 1'b0;
      kind_ok = 1'b0;
      case (ins_e'(ins_kind))
         INS_PP, INS_SE: begin
            is_mod  = 1'b1;
            kind_ok = !sec_hit;
         end
         INS_BE: begin
            is_mod  = 1'b1;
            kind_ok = (bp == '0);
         end
         INS_WRSR: begin
            is_mod  = 1'b1;
            kind_ok = !(srwd && !wp_n);
         end
         default: ;
      endcase
   end

   assign ok = is_mod && frame_ok && wel && !busy && kind_ok;
endmodule

// File: rtl/wp_wel_latch.sv
module wp_wel_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   input  logic start,
   input  logic done,
   output logic wel,
   output logic pending
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel     <= 1'b0;
         pending <= 1'b0;
      end else begin
         if (done && pending) begin
            wel     <= 1'b0;
            pending <= 1'b0;
         end
         if (start)   pending <= 1'b1;
         if (clr_req) wel     <= 1'b0;
         if (set_req) wel     <= 1'b1;
      end
   end
endmodule

// File: rtl/wp_gate.sv
module wp_gate
   import wp_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int SEC_W    = 6,
   parameter int BP_W     = 3,
   parameter bit USE_MASK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_rise,
   input  logic [2:0]       ins_kind,
   input  logic [CNT_W-1:0] bit_count,
   input  logic [SEC_W-1:0] sec_addr,
   input  logic             wp_n,
   input  logic             srwd,
   input  logic [BP_W-1:0]  bp,
   input  logic             dpd,
   input  logic             busy,
   input  logic             op_done,
   output logic             accept,
   output logic             reject,
   output logic             wel
);
   logic sec_hit, is_mod, ok, ev, pending;

   assign ev = cs_rise && !dpd;

   wp_sector_map #(.SEC_W(SEC_W), .BP_W(BP_W), .USE_MASK(USE_MASK)) u_map (
      .sec (sec_addr),
      .bp  (bp),
      .hit (sec_hit)
   );

   wp_admit #(.CNT_W(CNT_W), .BP_W(BP_W)) u_admit (
      .ins_kind  (ins_kind),
      .bit_count (bit_count),
      .wel       (wel),
      .busy      (busy),
      .bp        (bp),
      .srwd      (srwd),
      .wp_n      (wp_n),
      .sec_hit   (sec_hit),
      .is_mod    (is_mod),
      .ok        (ok)
   );

   wp_wel_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (ev && ins_kind == INS_WREN),
      .clr_req (ev && ins_kind == INS_WRDI),
      .start   (ev && ok),
      .done    (op_done),
      .wel     (wel),
      .pending (pending)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         accept <= 1'b0;
         reject <= 1'b0;
      end else begin
         accept <= ev && ok;
         reject <= ev && is_mod && !ok;
      end
   end
endmodule

// File: rtl/wp_gate_chk.sv
module wp_gate_chk #(
   parameter int CNT_W = 16,
   parameter int BP_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_rise,
   input logic [2:0]       ins_kind,
   input logic [CNT_W-1:0] bit_count,
   input logic             wp_n,
   input logic             srwd,
   input logic [BP_W-1:0]  bp,
   input logic             dpd,
   input logic             busy,
   input logic             op_done,
   input logic             accept,
   input logic             reject,
   input logic             wel
);
   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(accept && reject)); // R11
   AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) (accept || reject) |-> $past(cs_rise)); // R11
   AST_ACCEPT_WEL: assert property (@(posedge clk) disable iff (!rst_n) accept |-> $past(wel)); // R3
   AST_REJECT_KEEPS_WEL: assert property (@(posedge clk) disable iff (!rst_n) (reject && !$past(op_done)) |-> wel == $past(wel)); // R3
   AST_FRAME_BYTES: assert property (@(posedge clk) disable iff (!rst_n) accept |-> $past(bit_count[2:0]) == 3'd0); // R4
   AST_BULK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (accept && $past(ins_kind) == 3'd5) |-> $past(bp) == '0); // R6
   AST_SR_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (accept && $past(ins_kind) == 3'd6) |-> !($past(srwd) && !$past(wp_n))); // R7
   AST_DPD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $past(dpd) |-> !accept && !reject); // R8
   AST_DPD_WEL: assert property (@(posedge clk) disable iff (!rst_n) ($past(dpd) && !$past(op_done)) |-> $stable(wel)); // R8
   AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) $past(busy) |-> !accept); // R9
endmodule

bind wp_gate wp_gate_chk #(.CNT_W(CNT_W), .BP_W(BP_W)) u_chk (.*);

// File: tb/wp_gate_test.sv
module wp_gate_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_rise = 1'b0;
   logic [2:0]  ins_kind = 3'd0;
   logic [15:0] bit_count = 16'd0;
   logic [5:0]  sec_addr = 6'd0;
   logic        wp_n = 1'b1;
   logic        srwd = 1'b0;
   logic [2:0]  bp = 3'd0;
   logic        dpd = 1'b0;
   logic        busy = 1'b0;
   logic        op_done = 1'b0;
   logic        accept, reject, wel;

   int nchk = 0;
   int nerr = 0;
   bit wel_m = 1'b0;
   bit pend_m = 1'b0;

   always #10 clk = ~clk;

   wp_gate uut (.*);

   task automatic check(string tag, int act, int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic bit prot(int lvl, int sec);
      int cnt;
      cnt = (lvl == 0) ? 0 : (lvl == 7) ? 64 : (1 << (lvl - 1));
      return sec >= 64 - cnt;
   endfunction

   task automatic issue(string tag, int k, int bits, int sec);
      bit ea, er, kok;
      ea = 0; er = 0;
      @(negedge clk);
      ins_kind = 3'(k); bit_count = 16'(bits); sec_addr = 6'(sec); cs_rise = 1'b1;
      if (!dpd) begin
         if (k == 1) wel_m = 1;
         else if (k == 2) wel_m = 0;
         else if (k >= 3 && k <= 6) begin
            kok = (k == 5) ? (bp == 0) : (k == 6) ? !(srwd && !wp_n) : !prot(int'(bp), sec);
            if ((bits % 8) == 0 && wel_m && !busy && kok) begin ea = 1; pend_m = 1; end
            else er = 1;
         end
      end
      @(negedge clk);
      cs_rise = 1'b0; ins_kind = 3'd0;
      check({tag, " accept"}, int'(accept), int'(ea));
      check({tag, " reject"}, int'(reject), int'(er));
      check({tag, " wel"}, int'(wel), int'(wel_m));
   endtask

   task automatic finish_op(string tag);
      @(negedge clk);
      op_done = 1'b1;
      if (pend_m) begin wel_m = 0; pend_m = 0; end
      @(negedge clk);
      op_done = 1'b0;
      check({tag, " wel after done"}, int'(wel), int'(wel_m));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 wel", int'(wel), 0);
      check("R1 accept", int'(accept), 0);
      check("R1 reject", int'(reject), 0);

      issue("R3 no latch", 3, 32, 0);
      issue("R2 wren", 1, 8, 0);
      issue("R2 wrdi", 2, 8, 0);
      issue("R2 wren odd count", 1, 5, 0);
      issue("R4 short frame", 3, 39, 0);
      bp = 3'd1;
      issue("R5 level1 sector63", 3, 40, 63);
      issue("R5 level1 sector62", 3, 40, 62);
      @(negedge clk);
      check("R11 accept one cycle", int'(accept), 0);
      finish_op("R10 clear on done");
      issue("R2 wren", 1, 8, 0);
      finish_op("R10 spurious done");
      bp = 3'd6;
      issue("R5 level6 sector32", 4, 32, 32);
      issue("R5 level6 sector31", 4, 32, 31);
      finish_op("R10");
      issue("R2 wren", 1, 8, 0);
      bp = 3'd7;
      issue("R5 level7 sector0", 4, 32, 0);
      bp = 3'd1;
      issue("R6 bulk with level1", 5, 8, 0);
      bp = 3'd0;
      issue("R6 bulk level0", 5, 8, 0);
      finish_op("R10");
      issue("R2 wren", 1, 8, 0);
      srwd = 1'b1; wp_n = 1'b0;
      issue("R7 locked status write", 6, 16, 0);
      wp_n = 1'b1;
      issue("R7 pin high", 6, 16, 0);
      finish_op("R10");
      issue("R2 wren", 1, 8, 0);
      srwd = 1'b0; dpd = 1'b1;
      issue("R8 program in dpd", 3, 32, 0);
      issue("R8 wrdi in dpd", 2, 8, 0);
      dpd = 1'b0; busy = 1'b1;
      issue("R9 busy", 3, 32, 0);
      busy = 1'b0;

      for (int i = 0; i < 400; i++) begin
         int k, bits;
         bp   = 3'($urandom % 8);
         srwd = 1'($urandom % 2);
         wp_n = 1'($urandom % 2);
         dpd  = (($urandom % 8) == 0);
         busy = (($urandom % 6) == 0);
         k    = 1 + int'($urandom % 6);
         bits = 8 * (1 + int'($urandom % 5));
         if (($urandom % 5) == 0) bits = bits + 1 + int'($urandom % 7);
         issue("R5 R11 random", k, bits, int'($urandom % 64));
         if (($urandom % 5) == 0) finish_op("R10 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule